// File: doc/BRIEF.md
# Level-Requested Single-Channel DMA Mover

This block is a single DMA channel. It moves one data word per accepted request, from a source address to a destination address. Requests arrive on an active-low line, and the line is treated as a level. Once software has enabled the channel with level activation selected, the line is looked at on every clock. A low level is captured into an internal pending flag. The channel then raises a bus request and waits for the arbiter's grant. It reads one word from the source and writes that word to the destination. After that it hands the bus back.

Acceptance is closed from the moment a request is captured until the destination write has completed. Holding the line low therefore yields exactly one transfer per accept cycle, not a burst. A 16-bit count sets how many transfers make up a job. On the last write the channel disables itself, sets a sticky done flag and pulses an interrupt for one clock. The master port is a valid/ready handshake. The channel raises `m_valid` and keeps address, direction and write data steady until a cycle in which `m_ready` is high. The far side may stall any beat for any number of cycles, and read data is taken in the cycle of the read handshake.

Top module: `dma_level_chan`

## Requirements
- R1: After reset `bus_req`, `m_valid`, `done` and `irq` are all low.
- R2: With the level-activation bit (control bit 1) cleared, a low `dreq_n` starts nothing, even with the channel enabled (control bit 0).
- R3: `dreq_n` is first sampled on the clock edge after the edge that takes the enabling control write. A low seen only during that write cycle is not accepted.
- R4: A low level sampled while acceptance is open is held internally, so a single-cycle low pulse still produces a complete transfer.
- R5: At least two clocks separate the capture of a request from the start of the read. With grant present, `bus_req` rises one cycle after the capture edge and the read beat appears one cycle after that.
- R6: Each transfer is one read beat (`m_write`=0, `m_addr`=source) followed by one write beat (`m_write`=1, `m_addr`=destination, `m_wdata`=the word read). The read starts only after `bus_gnt` has been seen, and `bus_req` is low in the cycle after the write handshake.
- R7: `dreq_n` is ignored from capture until the write handshake. With the line held low, the next capture happens on the edge after that handshake, and `bus_req` returns one cycle later.
- R8: The count (register 3) decrements per write. The write that takes it from 1 to 0 clears the enable, sets `done` and raises `irq` for exactly one cycle, and no further request is accepted afterwards.
- R9: After each transfer the source address advances by one when control bit 2 is set. The destination advances by one when control bit 3 is set. Otherwise the address stays fixed, and arithmetic wraps at the address width.
- R10: Clearing the enable while a transfer is in flight lets that read/write pair complete and then captures no new request.
- R11: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_addr`, `m_write` and `m_wdata` hold their values.
- R12: Any write to the control register (address 0) clears `done`. Register addresses are 0 control, 1 source, 2 destination and 3 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | CFG_W | Register write data |
| dreq_n | input | 1 | Active-low level transfer request |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| m_valid | output | 1 | Master beat valid |
| m_ready | input | 1 | Master beat accepted |
| m_write | output | 1 | Beat direction, 1 = write |
| m_addr | output | ADDR_W | Beat address |
| m_wdata | output | DATA_W | Write data |
| m_rdata | input | DATA_W | Read data, taken at read handshake |
| done | output | 1 | Sticky job-complete flag |
| irq | output | 1 | One-cycle completion pulse |

## Verification
A request that is low on the edge after the enable write is captured on that edge. With grant present, `bus_req` is high one cycle after capture and the read beat two cycles after it. The write follows one cycle after an accepted read, and `bus_req` falls one cycle after the write handshake. `irq` and `done` are due in the cycle right after the final write handshake. The bench drives inputs on falling edges and reads outputs on the next falling edge, counting exactly those cycles. It logs handshakes at the falling edge before the rising edge that takes them. Whole jobs are compared only after `done` is seen.

// File: rtl/dmalv_pkg.sv
package dmalv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ARB, ST_READ, ST_WRITE} eng_state_t;
  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_SRC  = 2'd1;
  localparam logic [1:0] RA_DST  = 2'd2;
  localparam logic [1:0] RA_CNT  = 2'd3;
  localparam int CB_EN    = 0;
  localparam int CB_LEVEL = 1;
  localparam int CB_SINC  = 2;
  localparam int CB_DINC  = 3;
endpackage

// File: rtl/dmalv_regs.sv
module dmalv_regs
  import dmalv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int CFG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              step,
  output logic              en,
  output logic              level,
  output logic [ADDR_W-1:0] src,
  output logic [ADDR_W-1:0] dst,
  output logic              done,
  output logic              irq
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic             sinc, dinc;
  logic [CNT_W-1:0] cnt;

  // Engine bookkeeping first; a register write in the same cycle overrides it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      level <= 1'b0;
      sinc  <= 1'b0;
      dinc  <= 1'b0;
      src   <= '0;
      dst   <= '0;
      cnt   <= '0;
      done  <= 1'b0;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (step) begin
        if (sinc) src <= src + ADDR_W'(1);
        if (dinc) dst <= dst + ADDR_W'(1);
        cnt <= cnt - LAST;
        if (cnt == LAST) begin
          en   <= 1'b0;
          done <= 1'b1;
          irq  <= 1'b1;
        end
      end
      if (cfg_we) begin
        case (cfg_addr)
          RA_CTRL: begin
            en    <= cfg_wdata[CB_EN];
            level <= cfg_wdata[CB_LEVEL];
            sinc  <= cfg_wdata[CB_SINC];
            dinc  <= cfg_wdata[CB_DINC];
            done  <= 1'b0;
          end
          RA_SRC:  src <= cfg_wdata[ADDR_W-1:0];
          RA_DST:  dst <= cfg_wdata[ADDR_W-1:0];
          default: cnt <= cfg_wdata[CNT_W-1:0];
        endcase
      end
    end
  end
endmodule

// File: rtl/dmalv_sampler.sv
module dmalv_sampler #(
  parameter int MIN_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic level,
  input  logic dreq_n,
  input  logic idle,
  input  logic act,
  output logic pend,
  output logic gap_ok
);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(MIN_GAP - 1);

  logic [GAP_W-1:0] gap;
  logic             open_w;

  // Acceptance is open only in an idle engine with nothing held.
  assign open_w = en & level & idle & ~pend;
  assign gap_ok = pend & (gap >= GAP_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      gap  <= '0;
    end else if (act) begin
      pend <= 1'b0;
    end else if (open_w && !dreq_n) begin
      pend <= 1'b1;
      gap  <= '0;
    end else if (pend && gap != GAP_MAX) begin
      gap <= gap + GAP_W'(1);
    end
  end
endmodule

// File: rtl/dmalv_engine.sv
module dmalv_engine
  import dmalv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pend,
  input  logic              gap_ok,
  input  logic              bus_gnt,
  input  logic [ADDR_W-1:0] src,
  input  logic [ADDR_W-1:0] dst,
  input  logic              m_ready,
  input  logic [DATA_W-1:0] m_rdata,
  output eng_state_t        state,
  output logic              idle,
  output logic              act,
  output logic              step,
  output logic              bus_req,
  output logic              m_valid,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata
);
  eng_state_t        nxt;
  logic [ADDR_W-1:0] a_src, a_dst;

  assign idle    = (state == ST_IDLE);
  assign act     = (state == ST_ARB) & gap_ok & bus_gnt;
  assign step    = (state == ST_WRITE) & m_ready;
  assign bus_req = ~idle;
  assign m_valid = (state == ST_READ) | (state == ST_WRITE);
  assign m_write = (state == ST_WRITE);
  assign m_addr  = m_write ? a_dst : a_src;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (pend)    nxt = ST_ARB;
      ST_ARB:   if (act)     nxt = ST_READ;
      ST_READ:  if (m_ready) nxt = ST_WRITE;
      default:  if (m_ready) nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      a_src   <= '0;
      a_dst   <= '0;
      m_wdata <= '0;
    end else begin
      state <= nxt;
      if (act) begin
        a_src <= src;
        a_dst <= dst;
      end
      if (state == ST_READ && m_ready) m_wdata <= m_rdata;
    end
  end
endmodule

// File: rtl/dma_level_chan.sv
module dma_level_chan
  import dmalv_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int CNT_W   = 16,
  parameter int CFG_W   = 16,
  parameter int MIN_GAP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              dreq_n,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              m_valid,
  input  logic              m_ready,
  output logic              m_write,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata,
  output logic              done,
  output logic              irq
);
  logic              en_q, level_q, pend_q, gap_ok, idle, act, step;
  logic [ADDR_W-1:0] src_q, dst_q;
  eng_state_t        state;

  dmalv_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .CFG_W(CFG_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .step(step), .en(en_q), .level(level_q),
    .src(src_q), .dst(dst_q), .done(done), .irq(irq)
  );

  dmalv_sampler #(.MIN_GAP(MIN_GAP)) u_samp (
    .clk(clk), .rst_n(rst_n), .en(en_q), .level(level_q), .dreq_n(dreq_n),
    .idle(idle), .act(act), .pend(pend_q), .gap_ok(gap_ok)
  );

  dmalv_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .pend(pend_q), .gap_ok(gap_ok),
    .bus_gnt(bus_gnt), .src(src_q), .dst(dst_q), .m_ready(m_ready),
    .m_rdata(m_rdata), .state(state), .idle(idle), .act(act), .step(step),
    .bus_req(bus_req), .m_valid(m_valid), .m_write(m_write),
    .m_addr(m_addr), .m_wdata(m_wdata)
  );
endmodule

// File: rtl/dmalv_checks.sv
module dmalv_checks
  import dmalv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_q,
  input logic              level_q,
  input logic              pend_q,
  input logic              act,
  input eng_state_t        state,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              m_valid,
  input logic              m_ready,
  input logic              m_write,
  input logic [ADDR_W-1:0] m_addr,
  input logic [DATA_W-1:0] m_wdata,
  input logic              done,
  input logic              irq
);
  a_r3_capture_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(en_q && level_q));

  a_r5_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> $past(pend_q));

  a_r6_read_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_READ && $past(state) == ST_ARB) |-> $past(bus_gnt));

  a_r6_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && m_write) |=> !bus_req);

  a_r7_closed_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> !$rose(pend_q));

  a_r8_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r8_done_disables: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !en_q);

  a_r11_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_addr) && $stable(m_write)
                               && $stable(m_wdata)));
endmodule

bind dma_level_chan dmalv_checks #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .level_q(level_q), .pend_q(pend_q),
  .act(act), .state(state), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write), .m_addr(m_addr),
  .m_wdata(m_wdata), .done(done), .irq(irq)
);

// File: tb/test_dma_level_chan.sv
module test_dma_level_chan;
  localparam int AW = 16;
  localparam int DW = 16;
  // {src[38:23], dst[22:7], count[6:3], src_inc[2], dst_inc[1], stall[0]}
  localparam logic [38:0] VECS [0:3] = '{
    {16'h0100, 16'h0800, 4'd3, 1'b1, 1'b1, 1'b0},
    {16'h0200, 16'h0900, 4'd4, 1'b0, 1'b1, 1'b1},
    {16'h0300, 16'h0A00, 4'd2, 1'b1, 1'b0, 1'b1},
    {16'hFFFE, 16'h0B00, 4'd3, 1'b1, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [15:0]   cfg_wdata = '0;
  logic          dreq_n = 1'b1;
  logic          bus_req, bus_gnt = 1'b1;
  logic          m_valid, m_write, m_ready = 1'b1;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rdata;
  logic          done, irq;

  int checks = 0, fails = 0, cyc = 0, wr_n = 0, irq_n = 0, ready_mode = 0;
  logic [15:0] wr_addr [0:31];
  logic [15:0] wr_data [0:31];

  always #10 clk = ~clk;

  dma_level_chan i_dma_level_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .dreq_n(dreq_n), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .m_valid(m_valid), .m_ready(m_ready),
    .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .done(done), .irq(irq)
  );

  function automatic logic [15:0] mem_f(input logic [15:0] a);
    return a ^ 16'h5A3C;
  endfunction
  assign m_rdata = mem_f(m_addr);

  // Slave model: set ready for the coming edge, then log the beat it takes.
  always @(negedge clk) begin
    cyc++;
    case (ready_mode)
      0:       m_ready = 1'b1;
      1:       m_ready = (cyc % 3) != 0;
      default: m_ready = 1'b0;
    endcase
    if (m_valid && m_ready && m_write) begin
      if (wr_n < 32) begin
        wr_addr[wr_n] = m_addr;
        wr_data[wr_n] = m_wdata;
      end
      wr_n++;
    end
    if (irq) irq_n++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act_v, exp_v);
    end
  endtask

  task automatic cfg(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done();
    for (int g = 0; g < 400 && !done; g++) @(negedge clk);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 100000, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3);
    // R1: reset state
    chk(!bus_req && !m_valid && !done && !irq, "R1", "reset outputs",
        {bus_req, m_valid, done, irq}, 0);
    rst_n = 1'b1;
    tick(2);

    // Vector table: full jobs with varied increments and slave stalls.
    for (int r = 0; r < 4; r++) begin
      logic [38:0] v;
      logic [15:0] s, d, es, ed;
      int n;
      v = VECS[r];
      s = v[38:23]; d = v[22:7]; n = int'(v[6:3]);
      ready_mode = v[0] ? 1 : 0;
      wr_n = 0; irq_n = 0;
      cfg(2'd1, s); cfg(2'd2, d); cfg(2'd3, 16'(n));
      cfg(2'd0, {12'd0, v[1], v[2], 2'b11});
      dreq_n = 1'b0;
      wait_done();
      tick(2);
      dreq_n = 1'b1;
      chk(wr_n == n, "R8", "write count", wr_n, n);
      chk(irq_n == 1, "R8", "irq pulses", irq_n, 1);
      chk(done == 1'b1, "R8", "done flag", done, 1);
      for (int i = 0; i < n; i++) begin
        es = v[2] ? 16'(s + 16'(i)) : s;
        ed = v[1] ? 16'(d + 16'(i)) : d;
        chk(wr_addr[i] == ed, "R9", "write address", wr_addr[i], ed);
        chk(wr_data[i] == mem_f(es), "R6", "write data", wr_data[i], mem_f(es));
      end
      cfg(2'd0, 16'h0000);
      chk(done == 1'b0, "R12", "done cleared by control write", done, 0);
    end
    ready_mode = 0;
    tick(2);

    // R4 R5 R6: single-cycle low pulse, exact cycle timing with grant present
    wr_n = 0;
    cfg(2'd3, 16'd1); cfg(2'd1, 16'h0040); cfg(2'd2, 16'h0050);
    cfg(2'd0, 16'h0003);
    dreq_n = 1'b0;
    tick(1);
    dreq_n = 1'b1;
    chk(bus_req == 1'b0, "R5", "no bus_req on capture cycle", bus_req, 0);
    tick(1);
    chk(bus_req && !m_valid, "R5", "bus_req one cycle after capture",
        {bus_req, m_valid}, 2'b10);
    tick(1);
    chk(m_valid && !m_write && m_addr == 16'h0040, "R6", "read beat",
        m_addr, 16'h0040);
    tick(1);
    chk(m_valid && m_write && m_addr == 16'h0050 && m_wdata == mem_f(16'h0040),
        "R6", "write beat data", m_wdata, mem_f(16'h0040));
    tick(1);
    chk(!bus_req && done, "R6", "bus_req dropped after write", bus_req, 0);
    chk(wr_n == 1, "R4", "held pulse gave one transfer", wr_n, 1);

    // R3: low only during the enabling write cycle is not taken
    cfg(2'd3, 16'd1);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 16'h0003; dreq_n = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0; dreq_n = 1'b1;
    for (int k = 0; k < 5; k++) begin
      chk(bus_req == 1'b0, "R3", "no capture on enable edge", bus_req, 0);
      tick(1);
    end

    // R2: level mode bit clear leaves the request line ignored
    wr_n = 0;
    cfg(2'd3, 16'd2); cfg(2'd0, 16'h0001);
    dreq_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      tick(1);
      chk(bus_req == 1'b0, "R2", "no request without level mode", bus_req, 0);
    end
    dreq_n = 1'b1;
    chk(wr_n == 0, "R2", "no writes", wr_n, 0);
    cfg(2'd0, 16'h0000);

    // R7 R8: held-low line, re-accept timing, stop at zero count
    wr_n = 0; irq_n = 0;
    cfg(2'd3, 16'd3); cfg(2'd1, 16'h0100); cfg(2'd2, 16'h0200);
    cfg(2'd0, 16'h000F);
    dreq_n = 1'b0;
    tick(5);
    chk(bus_req == 1'b0 && wr_n == 1, "R7", "req low after first write",
        bus_req, 0);
    tick(1);
    chk(bus_req == 1'b0, "R7", "re-capture cycle", bus_req, 0);
    tick(1);
    chk(bus_req == 1'b1, "R7", "req back after re-capture", bus_req, 1);
    wait_done();
    tick(10);
    chk(wr_n == 3, "R8", "no transfers past zero count", wr_n, 3);
    chk(irq_n == 1, "R8", "single irq", irq_n, 1);
    chk(wr_addr[2] == 16'h0202, "R9", "dst advanced", wr_addr[2], 16'h0202);
    dreq_n = 1'b1;
    cfg(2'd0, 16'h0000);
    chk(done == 1'b0, "R12", "done cleared", done, 0);

    // R10: disable while a transfer is in flight
    wr_n = 0;
    cfg(2'd3, 16'd5); cfg(2'd0, 16'h0003);
    dreq_n = 1'b0;
    tick(3);
    cfg(2'd0, 16'h0002);
    tick(20);
    chk(wr_n == 1, "R10", "in-flight pair finished, no more", wr_n, 1);
    chk(!bus_req && !done, "R10", "stopped without done", {bus_req, done}, 0);
    dreq_n = 1'b1;

    // R11: stalled read beat holds
    begin
      logic [15:0] a0;
      wr_n = 0;
      ready_mode = 2;
      cfg(2'd3, 16'd1); cfg(2'd1, 16'h0300); cfg(2'd0, 16'h0003);
      dreq_n = 1'b0;
      tick(4);
      a0 = m_addr;
      chk(m_valid && !m_write && a0 == 16'h0300, "R11", "stalled read valid",
          a0, 16'h0300);
      tick(3);
      chk(m_valid && !m_write && m_addr == a0, "R11", "read beat held", m_addr, a0);
      ready_mode = 0;
      wait_done();
      dreq_n = 1'b1;
      tick(2);
      chk(wr_n == 1 && wr_data[0] == mem_f(16'h0300), "R11", "data after stall",
          wr_data[0], mem_f(16'h0300));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule